// File: doc/BRIEF.md
# Peripheral Word DMA Channel

This block is one DMA channel. It moves 32-bit words between a memory-side port and a peripheral-side port. Software configures it through three registers: control, status and a global gate. It then either runs a single block of words to completion or loops forever over a two-half buffer. The channel counts words down from a programmed value. When the count runs out it raises an end-of-count flag, and it can drive an interrupt line from that flag.

In one-shot mode the channel stops by itself at the end of the block. In continuous mode the programmed count covers only one half of the buffer. At the end of each half the channel flags end-of-count, flips a half indicator, reloads the count and carries on without software help. A flow-control option paces the words on a selected peripheral request line. A hold bit and the global gate freeze the channel in place, so the remaining count can be read back while it is stopped.

Top module: `pdma_channel`

## Requirements
- R1: After reset, the control, status and global registers all read zero, the interrupt is low and no transfer strobe is active.
- R2: The control register is at address 0. Its fields are: run bit 31, interrupt enable bit 30, hold bit 29, direction bit 28, one-shot bit 27, flow-control bit 21, request select in bits 20:16, and count (words minus one) in bits 15:2. Every other bit reads back as zero. The global register is at address 2, with its gate in bit 31.
- R3: Writing the control register with the run bit set while the channel is idle loads the count and starts the channel. In one-shot mode with count N, the channel moves exactly N+1 words, one word per decrement. It then sets end-of-count (status bit 30) and clears busy (status bit 31).
- R4: In continuous mode with count N, each group of N+1 words sets end-of-count, toggles the half indicator (status bit 28, cleared at start), reloads the count to N and keeps busy set.
- R5: The status register is at address 1. Writing it with bit 30 set clears end-of-count. Writing it with bit 30 clear leaves end-of-count unchanged.
- R6: The interrupt output is high exactly when end-of-count is set and the interrupt enable bit is set.
- R7: With flow control set, a word moves only in a cycle where the peripheral request line chosen by the request select is high. Other request lines have no effect. With flow control clear, words move back to back while both ports are ready.
- R8: While the global gate is clear, a busy channel moves no words, the remaining count and half indicator stay unchanged, and the halt flag (status bit 29) reads one.
- R9: While the hold bit is set, a busy channel moves no words and the halt flag reads one. Clearing hold through a control write made while busy resumes the run where it stopped, without reloading.
- R10: A control write with the run bit clear stops the channel. No word moves in the cycle of that write or afterwards, and busy reads zero after it.
- R11: Status bits 15:2 read the live remaining count of the channel.
- R12: With direction 1 each word pulses the memory read and peripheral write strobes. With direction 0 each word pulses the peripheral read and memory write strobes. The memory write data is the peripheral read data, and the peripheral write data is the memory read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 global |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| per_req | input | 2**SEL_W | Peripheral request lines |
| mem_ready | input | 1 | Memory side can take part in a word this cycle |
| per_ready | input | 1 | Peripheral side can take part in a word this cycle |
| mem_rdata | input | DATA_W | Word read from memory |
| per_rdata | input | DATA_W | Word read from the peripheral |
| mem_rd | output | 1 | Memory read strobe for a word |
| mem_wr | output | 1 | Memory write strobe for a word |
| per_rd | output | 1 | Peripheral read strobe for a word |
| per_wr | output | 1 | Peripheral write strobe for a word |
| mem_wdata | output | DATA_W | Word written to memory |
| per_wdata | output | DATA_W | Word written to the peripheral |
| irq | output | 1 | End-of-count interrupt |

## Verification
The bound checker watches every cycle for these rules: the count drops by exactly one per word, a one-shot run ends idle with end-of-count set, a continuous half ends busy with the half indicator flipped, and a disable write leaves the channel idle. It also checks that a closed global gate keeps the count and half indicator frozen, that no word moves while flow control waits on a low request line, and that a clear-write removes end-of-count. Other behaviour needs the bench's scenarios to show it. This covers the exact number of words per block across several counts and both directions, the reload value and the interrupt gating. It also covers register readback masking, hold followed by a resume, and the live count read partway through a half.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;

  // register select values
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_GLOB = 2'd2;

  // control fields
  localparam int B_RUN   = 31;
  localparam int B_IRQEN = 30;
  localparam int B_HOLD  = 29;
  localparam int B_DIR   = 28;
  localparam int B_ONCE  = 27;
  localparam int B_FLOW  = 21;
  localparam int SEL_LO  = 16;
  localparam int CNT_LO  = 2;
  localparam int CNT_HI  = 15;
  localparam int CNT_W   = CNT_HI - CNT_LO + 1;

  // status fields
  localparam int B_BUSY = 31;
  localparam int B_EOC  = 30;
  localparam int B_HALT = 29;
  localparam int B_PP   = 28;

  // global gate
  localparam int B_GATE = 31;
endpackage

// File: rtl/pdma_req_sel.sv
module pdma_req_sel #(
  parameter int SEL_W = 5
) (
  input  logic [(1<<SEL_W)-1:0] req,
  input  logic [SEL_W-1:0]      sel,
  output logic                  hit
);
  localparam int N_REQ = 1 << SEL_W;

  logic [N_REQ-1:0] match;

  for (genvar i = 0; i < N_REQ; i++) begin : g_line
    assign match[i] = req[i] && (sel == SEL_W'(i));
  end

  assign hit = |match;
endmodule

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int SEL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              st_busy,
  input  logic              st_eoc,
  input  logic              st_halt,
  input  logic              st_pp,
  input  logic [CNT_W-1:0]  st_cnt,
  output logic              irq_en,
  output logic              hold,
  output logic              dir,
  output logic              once,
  output logic              flow,
  output logic [SEL_W-1:0]  sel,
  output logic [CNT_W-1:0]  reload_cnt,
  output logic              gate,
  output logic              start,
  output logic              stop,
  output logic              eoc_clr,
  output logic [CNT_W-1:0]  load_cnt
);
  localparam logic [REG_W-1:0] SEL_MASK  = REG_W'(((1 << SEL_W) - 1) << SEL_LO);
  localparam logic [REG_W-1:0] CNT_MASK  = REG_W'(((1 << CNT_W) - 1) << CNT_LO);
  localparam logic [REG_W-1:0] CTRL_MASK = REG_W'((32'h1F << B_ONCE) | (32'h1 << B_FLOW)) |
                                           SEL_MASK | CNT_MASK;

  logic [REG_W-1:0] cfg_q, cfg_d;
  logic             gate_q, gate_d;
  logic             ctrl_wr, glob_wr;
  logic [REG_W-1:0] stat_word, glob_word;

  // decode
  assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
  assign glob_wr  = reg_wr && (reg_addr == A_GLOB);
  assign eoc_clr  = reg_wr && (reg_addr == A_STAT) && reg_wdata[B_EOC];
  assign start    = ctrl_wr && reg_wdata[B_RUN] && !st_busy;
  assign stop     = ctrl_wr && !reg_wdata[B_RUN];
  assign load_cnt = reg_wdata[CNT_HI:CNT_LO];

  // next state
  always_comb begin
    cfg_d  = reg_wdata & CTRL_MASK;
    gate_d = reg_wdata[B_GATE];
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      if (ctrl_wr) cfg_q  <= cfg_d;
      if (glob_wr) gate_q <= gate_d;
    end
  end

  assign irq_en     = cfg_q[B_IRQEN];
  assign hold       = cfg_q[B_HOLD];
  assign dir        = cfg_q[B_DIR];
  assign once       = cfg_q[B_ONCE];
  assign flow       = cfg_q[B_FLOW];
  assign sel        = cfg_q[SEL_LO +: SEL_W];
  assign reload_cnt = cfg_q[CNT_HI:CNT_LO];
  assign gate       = gate_q;

  // read mux
  always_comb begin
    stat_word                = '0;
    stat_word[B_BUSY]        = st_busy;
    stat_word[B_EOC]         = st_eoc;
    stat_word[B_HALT]        = st_halt;
    stat_word[B_PP]          = st_pp;
    stat_word[CNT_HI:CNT_LO] = st_cnt;
    glob_word                = '0;
    glob_word[B_GATE]        = gate_q;
    case (reg_addr)
      A_CTRL:  reg_rdata = cfg_q;
      A_STAT:  reg_rdata = stat_word;
      A_GLOB:  reg_rdata = glob_word;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
  import pdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             eoc_clr,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic [CNT_W-1:0] reload_cnt,
  input  logic             once,
  input  logic             hold,
  input  logic             flow,
  input  logic             gate,
  input  logic             req_hit,
  input  logic             mem_ready,
  input  logic             per_ready,
  output logic             busy,
  output logic             eoc,
  output logic             pp,
  output logic [CNT_W-1:0] cnt,
  output logic             beat
);
  logic             busy_d, eoc_d, pp_d;
  logic [CNT_W-1:0] cnt_d;
  logic             last;

  // one word moves when every gate is open; a disable write blocks it
  assign beat = busy && gate && !hold && !stop && mem_ready && per_ready &&
                (!flow || req_hit);
  assign last = (cnt == '0);

  always_comb begin
    busy_d = busy;
    eoc_d  = eoc;
    pp_d   = pp;
    cnt_d  = cnt;
    if (eoc_clr) eoc_d = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = load_cnt;
      pp_d   = 1'b0;
    end else if (stop) begin
      busy_d = 1'b0;
    end else if (beat) begin
      if (last) begin
        eoc_d = 1'b1;
        if (once) begin
          busy_d = 1'b0;
        end else begin
          cnt_d = reload_cnt;
          pp_d  = !pp;
        end
      end else begin
        cnt_d = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      eoc  <= 1'b0;
      pp   <= 1'b0;
      cnt  <= '0;
    end else begin
      busy <= busy_d;
      eoc  <= eoc_d;
      pp   <= pp_d;
      cnt  <= cnt_d;
    end
  end
endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
  import pdma_pkg::*;
#(
  parameter int SEL_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [1:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [(1<<SEL_W)-1:0] per_req,
  input  logic                  mem_ready,
  input  logic                  per_ready,
  input  logic [DATA_W-1:0]     mem_rdata,
  input  logic [DATA_W-1:0]     per_rdata,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic                  per_rd,
  output logic                  per_wr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [DATA_W-1:0]     per_wdata,
  output logic                  irq
);
  logic             irq_en, hold, dir, once_q, flow_q, glob_en;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] reload_cnt, load_cnt, cnt;
  logic             start, stop, eoc_clr;
  logic             busy, eoc, pp, beat, halt, req_hit;

  assign halt = busy && (!glob_en || hold);

  pdma_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .st_busy(busy), .st_eoc(eoc), .st_halt(halt), .st_pp(pp), .st_cnt(cnt),
    .irq_en(irq_en), .hold(hold), .dir(dir), .once(once_q), .flow(flow_q),
    .sel(sel), .reload_cnt(reload_cnt), .gate(glob_en),
    .start(start), .stop(stop), .eoc_clr(eoc_clr), .load_cnt(load_cnt)
  );

  pdma_req_sel #(.SEL_W(SEL_W)) u_req_sel (
    .req(per_req), .sel(sel), .hit(req_hit)
  );

  pdma_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .stop(stop), .eoc_clr(eoc_clr),
    .load_cnt(load_cnt), .reload_cnt(reload_cnt),
    .once(once_q), .hold(hold), .flow(flow_q), .gate(glob_en), .req_hit(req_hit),
    .mem_ready(mem_ready), .per_ready(per_ready),
    .busy(busy), .eoc(eoc), .pp(pp), .cnt(cnt), .beat(beat)
  );

  // word strobes by direction; data passes straight across
  assign mem_rd    = beat && dir;
  assign per_wr    = beat && dir;
  assign per_rd    = beat && !dir;
  assign mem_wr    = beat && !dir;
  assign mem_wdata = per_rdata;
  assign per_wdata = mem_rdata;
  assign irq       = eoc && irq_en;
endmodule

// File: rtl/pdma_channel_chk.sv
module pdma_channel_chk
  import pdma_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             glob_en,
  input logic             busy,
  input logic             eoc,
  input logic             pp,
  input logic [CNT_W-1:0] cnt,
  input logic             once_q,
  input logic             flow_q,
  input logic             req_hit,
  input logic             mem_rd,
  input logic             mem_wr
);
  logic moved;
  assign moved = mem_rd || mem_wr;

  // R3: each word steps the count down by one
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (moved && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  // R3: last one-shot word leaves the channel idle with end-of-count
  p_once_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (moved && cnt == '0 && once_q) |=> (!busy && eoc));

  // R4: last word of a half keeps running, flags and flips the half
  p_half_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (moved && cnt == '0 && !once_q) |=> (busy && eoc && (pp != $past(pp))));

  // R5: clear-write removes end-of-count when no word ends a block
  p_eoc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT && reg_wdata[B_EOC] && !moved) |=> !eoc);

  // R7: flow control waits on the selected request
  p_flow_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_q && !req_hit) |-> !moved);

  // R8: closed gate freezes count and half indicator
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !reg_wr) |=> ($stable(cnt) && $stable(pp)));

  // R10: disable write leaves the channel idle
  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL && !reg_wdata[B_RUN]) |=> !busy);
endmodule

bind pdma_channel pdma_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .glob_en(glob_en), .busy(busy), .eoc(eoc), .pp(pp), .cnt(cnt),
  .once_q(once_q), .flow_q(flow_q), .req_hit(req_hit), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/test_pdma_channel.sv
module test_pdma_channel;
  import pdma_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int SEL_W      = 5;
  localparam int DATA_W     = 32;

  typedef struct packed {
    logic        dir;
    logic        ie;
    logic [13:0] wcnt;
    logic [15:0] exp_words;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 1'b1, 14'd0,  16'd1},
    '{1'b1, 1'b0, 14'd1,  16'd2},
    '{1'b0, 1'b1, 14'd5,  16'd6},
    '{1'b1, 1'b1, 14'd20, 16'd21},
    '{1'b0, 1'b0, 14'd63, 16'd64}
  };

  logic                  clk, rst_n, reg_wr;
  logic [1:0]            reg_addr;
  logic [31:0]           reg_wdata, reg_rdata;
  logic [(1<<SEL_W)-1:0] per_req;
  logic                  mem_ready, per_ready;
  logic [DATA_W-1:0]     mem_rdata, per_rdata, mem_wdata, per_wdata;
  logic                  mem_rd, mem_wr, per_rd, per_wr, irq;

  pdma_channel #(.SEL_W(SEL_W), .DATA_W(DATA_W)) i_pdma_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
    .mem_ready(mem_ready), .per_ready(per_ready), .mem_rdata(mem_rdata),
    .per_rdata(per_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .per_rd(per_rd),
    .per_wr(per_wr), .mem_wdata(mem_wdata), .per_wdata(per_wdata), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  int n_chk = 0;
  int n_bad = 0;
  int words = 0;
  int n_memrd = 0;
  int n_perrd = 0;
  logic strobe_seen = 1'b0;

  always @(posedge clk) if (mem_rd || mem_wr) words <= words + 1;
  always @(posedge clk) if (mem_rd) n_memrd <= n_memrd + 1;
  always @(posedge clk) if (per_rd) n_perrd <= n_perrd + 1;
  always @(posedge clk) if (!rst_n && (mem_rd || mem_wr || per_rd || per_wr)) strobe_seen <= 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic poll(input int bitpos, input logic val, input int limit);
    logic [31:0] s;
    for (int i = 0; i < limit; i++) begin
      rd(A_STAT, s);
      if (s[bitpos] == val) return;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] mk(input logic run, input logic ie, input logic hold,
                                     input logic dir, input logic once, input logic flow,
                                     input logic [4:0] sel, input logic [13:0] cnt);
    logic [31:0] w;
    w = '0;
    w[B_RUN] = run; w[B_IRQEN] = ie; w[B_HOLD] = hold; w[B_DIR] = dir;
    w[B_ONCE] = once; w[B_FLOW] = flow; w[20:16] = sel; w[15:2] = cnt;
    return w;
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] s, s2;
    int b0, m0, p0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    per_req = '0; mem_ready = 1'b1; per_ready = 1'b1;
    mem_rdata = '0; per_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, s); chk("R1 control", s, 32'h0);
    rd(A_STAT, s); chk("R1 status", s, 32'h0);
    rd(A_GLOB, s); chk("R1 global", s, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 strobes", {31'b0, strobe_seen}, 32'h0);

    // R2 register masking
    wr(A_CTRL, 32'h7FFF_FFFF);
    rd(A_CTRL, s); chk("R2 control mask", s, 32'h783F_FFFC);
    wr(A_GLOB, 32'hFFFF_FFFF);
    rd(A_GLOB, s); chk("R2 global mask", s, 32'h8000_0000);
    wr(A_CTRL, 32'h0);

    // R3 / R12 / R6 / R5 one-shot table
    foreach (VECS[k]) begin
      b0 = words; m0 = n_memrd; p0 = n_perrd;
      wr(A_CTRL, mk(1'b1, VECS[k].ie, 1'b0, VECS[k].dir, 1'b1, 1'b0, 5'd0, VECS[k].wcnt));
      poll(B_BUSY, 1'b0, 300);
      rd(A_STAT, s);
      chk("R3 words", 32'(words - b0), 32'(VECS[k].exp_words));
      chk("R3 eoc and idle", {30'b0, s[31:30]}, 32'h1);
      chk("R12 direction strobes",
          VECS[k].dir ? 32'(n_memrd - m0) : 32'(n_perrd - p0), 32'(VECS[k].exp_words));
      chk("R6 irq gating", {31'b0, irq}, {31'b0, VECS[k].ie});
      wr(A_STAT, 32'h4000_0000);
      rd(A_STAT, s); chk("R5 clear", {31'b0, s[B_EOC]}, 32'h0);
    end

    // R4 / R11 continuous halves
    b0 = words;
    wr(A_CTRL, mk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 14'd2));
    poll(B_EOC, 1'b1, 50);
    mem_ready = 1'b0;
    rd(A_STAT, s);
    chk("R4 first half words", 32'(words - b0), 32'd3);
    chk("R4 half flag busy", {29'b0, s[B_BUSY], s[B_EOC], s[B_PP]}, 32'h7);
    chk("R4 reload", {18'b0, s[15:2]}, 32'd2);
    wr(A_STAT, 32'h4000_0000);
    rd(A_STAT, s); chk("R5 clear in run", {31'b0, s[B_EOC]}, 32'h0);
    @(negedge clk); mem_ready = 1'b1;
    @(negedge clk); mem_ready = 1'b0;
    rd(A_STAT, s); chk("R11 live count", {18'b0, s[15:2]}, 32'd1);
    mem_ready = 1'b1;
    poll(B_EOC, 1'b1, 50);
    mem_ready = 1'b0;
    rd(A_STAT, s);
    chk("R4 second half words", 32'(words - b0), 32'd6);
    chk("R4 half flips back", {30'b0, s[B_BUSY], s[B_PP]}, 32'h2);
    wr(A_STAT, 32'h4000_0000);
    mem_ready = 1'b1;

    // R8 global gate freeze
    wr(A_GLOB, 32'h0);
    rd(A_STAT, s);
    chk("R8 halted busy", {30'b0, s[B_BUSY], s[B_HALT]}, 32'h3);
    b0 = words;
    repeat (6) @(negedge clk);
    rd(A_STAT, s2);
    chk("R8 count stable", {18'b0, s2[15:2]}, {18'b0, s[15:2]});
    chk("R8 no words", 32'(words - b0), 32'd0);
    wr(A_GLOB, 32'h8000_0000);
    repeat (3) @(negedge clk);
    chk("R8 resumes", {31'b0, words != b0}, 32'h1);

    // R10 disable stops at once
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 32'h0;
    b0 = words;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R10 no word on disable edge", 32'(words - b0), 32'd0);
    rd(A_STAT, s); chk("R10 idle", {31'b0, s[B_BUSY]}, 32'h0);
    repeat (5) @(negedge clk);
    chk("R10 stays stopped", 32'(words - b0), 32'd0);

    // R9 hold
    b0 = words;
    wr(A_CTRL, mk(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0, 14'd4));
    repeat (5) @(negedge clk);
    rd(A_STAT, s);
    chk("R9 held", {30'b0, s[B_BUSY], s[B_HALT]}, 32'h3);
    chk("R9 held count", {18'b0, s[15:2]}, 32'd4);
    chk("R9 no words", 32'(words - b0), 32'd0);
    wr(A_CTRL, mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 14'd4));
    poll(B_BUSY, 1'b0, 50);
    chk("R9 resume words", 32'(words - b0), 32'd5);
    wr(A_STAT, 32'h4000_0000);

    // R7 flow control
    b0 = words;
    wr(A_CTRL, mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd7, 14'd2));
    repeat (8) @(negedge clk);
    chk("R7 waits on request", 32'(words - b0), 32'd0);
    per_req[3] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 other line ignored", 32'(words - b0), 32'd0);
    per_req = '0;
    per_req[7] = 1'b1;
    @(negedge clk);
    per_req = '0;
    rd(A_STAT, s);
    chk("R7 one word per request", 32'(words - b0), 32'd1);
    chk("R7 count after one", {18'b0, s[15:2]}, 32'd1);
    per_req[7] = 1'b1;
    poll(B_BUSY, 1'b0, 50);
    per_req = '0;
    chk("R7 block done", 32'(words - b0), 32'd3);

    // R6 with enable clear, R5 zero write
    rd(A_STAT, s);
    chk("R6 eoc set irq low", {30'b0, s[B_EOC], irq}, 32'h2);
    wr(A_STAT, 32'hBFFF_FFFF);
    rd(A_STAT, s); chk("R5 zero bit keeps eoc", {31'b0, s[B_EOC]}, 32'h1);

    // R12 data pass-through
    per_rdata = 32'hA5A5_0001; mem_rdata = 32'h5A5A_0002;
    #1;
    chk("R12 memory write data", mem_wdata, 32'hA5A5_0001);
    chk("R12 peripheral write data", per_wdata, 32'h5A5A_0002);

    finish_run();
  end
endmodule